// File: doc/BRIEF.md
# Logical Channel Conversion Scheduler

This block runs one logical channel of a multi-input sampling converter. It keeps the channel's run state, which is an enable bit and a one-shot bit. It issues conversion requests to a converter port that uses a start/busy/done/data handshake. It spaces successive requests with a reloadable interval timer. When averaging is on, it sums a power-of-two number of samples before it publishes a 12-bit result together with a one-cycle result pulse.

Software-facing state is written through a single strobe that carries the new enable and one-shot values. Every other setting (input select, interval, averaging switch and code) is a plain input. The select is sampled at each conversion start. The averaging settings are sampled at the first sample of a group. No request is issued unless the converter reports power-ready and is not busy. A converter that never answers is abandoned after a fixed cycle budget.

Top module: `lcs_chan_sched`

## Requirements
- R1: After a synchronous active-low reset, conv_start, result, result_valid, timeout, stat_enable and stat_single are all 0.
- R2: conv_start is a one-cycle pulse. It is issued only when, in the cycle before, stat_enable was 1, pwr_ready was 1 and conv_busy was 0. While pwr_ready stays 0 no start is issued. conv_sel carries the value cfg_sel had when the start was issued.
- R3: In continuous operation, let I be cfg_interval and D the number of cycles from a start pulse to the cycle in which conv_done is sampled. The next start follows the previous one by exactly max(I, D) + 1 cycles. An interval of 0 therefore gives back-to-back conversions.
- R4: With stat_enable = 1 and stat_single = 1, the channel completes exactly one result group. In the cycle its result_valid rises, both stat_enable and stat_single are 0. No further start follows.
- R5: A write (wr_stb = 1) is accepted when stat_enable is 0 or when wr_enable is 0. A write with wr_enable = 1 while stat_enable is 1 is ignored, so the mode cannot change while the channel runs.
- R6: With cfg_avg_on = 1, code c on cfg_avg_code (0..3) selects a group of 4 << c samples. The result is the truncated sum shifted right by c + 2. Thirty-two samples of 4095 give 4095.
- R7: With cfg_avg_on = 0, every conv_done publishes conv_data unchanged.
- R8: result_valid is a one-cycle pulse raised only after the last sample of a group. result changes only in the cycle result_valid is 1.
- R9: If conv_done does not arrive within TIMEOUT_CYC cycles of a start, timeout pulses exactly TIMEOUT_CYC cycles after that start, without result_valid. Any partial group is discarded and the channel returns to idle.
- R10: Clearing enable discards a partial averaging group. The next enable starts a fresh group that uses the averaging settings present at that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_stb | input | 1 | Run-state write strobe |
| wr_enable | input | 1 | Enable value carried by the write |
| wr_single | input | 1 | One-shot value carried by the write |
| cfg_sel | input | SEL_W | Physical input to convert |
| cfg_interval | input | TMR_W | Cycles between successive starts |
| cfg_avg_on | input | 1 | Averaging switch |
| cfg_avg_code | input | 2 | Averaging size code (4 << code samples) |
| pwr_ready | input | 1 | Converter fully powered up |
| conv_busy | input | 1 | Converter busy |
| conv_done | input | 1 | Converter sample ready, one cycle |
| conv_data | input | RES_W | Converter sample |
| conv_start | output | 1 | Conversion request pulse |
| conv_sel | output | SEL_W | Input select sent with the request |
| result | output | RES_W | Published (averaged) result |
| result_valid | output | 1 | Result update pulse |
| timeout | output | 1 | Converter no-answer pulse |
| stat_enable | output | 1 | Current enable state |
| stat_single | output | 1 | Current one-shot state |

## Verification
The bench builds the block with the default select, interval and result widths. It reduces TIMEOUT_CYC to 40, so the no-answer path is reached after a short wait and the exact firing cycle can be measured. Its converter model has a variable latency, which lets the interval-dominated and latency-dominated branches of the start spacing both be exercised. Each of the four averaging codes is run, including the saturating all-ones group of 32 samples.

// File: rtl/lcs_pkg.sv
// Package: shared types and constants for the logical channel scheduler.
// Assumes averaging groups are powers of two from 4 up to 1 << MAX_SHIFT.
package lcs_pkg;
    localparam int MAX_SHIFT  = 5;
    localparam int AVG_CODE_W = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CONV = 2'd1,
        ST_GAP  = 2'd2
    } lcs_state_e;
endpackage

// File: rtl/lcs_mode_reg.sv
// Module: holds the run-state bits (enable, one-shot).
// A write is taken only when the channel is stopped or the write stops it.
// A finished one-shot run clears both bits.
module lcs_mode_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_stb,
    input  logic wr_enable,
    input  logic wr_single,
    input  logic finish_single,
    output logic en_q,
    output logic single_q
);
    logic wr_ok;

    // accept a write only while stopped or when it stops the channel
    always_comb wr_ok = wr_stb && (!en_q || !wr_enable);

    // run-state register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            single_q <= 1'b0;
        end else if (wr_ok) begin
            en_q     <= wr_enable;
            single_q <= wr_single;
        end else if (finish_single) begin
            en_q     <= 1'b0;
            single_q <= 1'b0;
        end
    end
endmodule

// File: rtl/lcs_ivl_timer.sv
// Module: interval down-counter. It reloads on each conversion start and
// reports expiry at zero. Assumes load wins over decrement.
module lcs_ivl_timer #(
    parameter int TMR_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TMR_W-1:0] load_val,
    output logic             expired
);
    logic [TMR_W-1:0] cnt_q;

    // count down to zero, reload on start
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt_q <= '0;
        else if (load)            cnt_q <= load_val;
        else if (cnt_q != '0)     cnt_q <= cnt_q - TMR_W'(1);
    end

    // expiry flag
    always_comb expired = (cnt_q == '0);
endmodule

// File: rtl/lcs_avg_accum.sv
// Module: sample accumulator for power-of-two averaging.
// The averaging settings are sampled at the first sample of a group and held
// for the rest of it. group_done and avg_out are combinational on the sample
// that completes a group.
module lcs_avg_accum
    import lcs_pkg::*;
#(
    parameter int RES_W = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear,
    input  logic                  sample_vld,
    input  logic [RES_W-1:0]      sample,
    input  logic                  avg_on,
    input  logic [AVG_CODE_W-1:0] avg_code,
    output logic                  group_done,
    output logic [RES_W-1:0]      avg_out
);
    localparam int ACC_W = RES_W + MAX_SHIFT;
    localparam int CNT_W = MAX_SHIFT + 1;

    logic [ACC_W-1:0]      acc_q;
    logic [CNT_W-1:0]      cnt_q;
    logic                  on_q;
    logic [AVG_CODE_W-1:0] code_q;

    logic                  eff_on;
    logic [AVG_CODE_W-1:0] eff_code;
    logic [CNT_W-1:0]      target;
    logic [2:0]            shift;
    logic [ACC_W-1:0]      sum_next;
    logic [ACC_W-1:0]      avg_full;

    // settings in force: live at group start, held afterwards
    always_comb begin
        eff_on   = (cnt_q == '0) ? avg_on   : on_q;
        eff_code = (cnt_q == '0) ? avg_code : code_q;
    end

    // group size, shift and running sum
    always_comb begin
        target   = eff_on ? (CNT_W'(4) << eff_code) : CNT_W'(1);
        shift    = eff_on ? (3'(eff_code) + 3'd2) : 3'd0;
        sum_next = acc_q + ACC_W'(sample);
        avg_full = sum_next >> shift;
        avg_out  = avg_full[RES_W-1:0];
        group_done = sample_vld && (CNT_W'(cnt_q + CNT_W'(1)) == target);
    end

    // accumulate, restart on group end or clear
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            acc_q  <= '0;
            cnt_q  <= '0;
            on_q   <= 1'b0;
            code_q <= '0;
        end else if (sample_vld) begin
            if (group_done) begin
                acc_q <= '0;
                cnt_q <= '0;
            end else begin
                acc_q  <= sum_next;
                cnt_q  <= cnt_q + CNT_W'(1);
                on_q   <= eff_on;
                code_q <= eff_code;
            end
        end
    end
endmodule

// File: rtl/lcs_conv_seq.sv
// Module: conversion sequencer with a no-answer watchdog.
// It issues starts when enabled, powered and not busy, waits for done, paces
// the next start with the interval timer, and ends a one-shot group.
// Assumes conv_done is a one-cycle pulse per start.
module lcs_conv_seq
    import lcs_pkg::*;
#(
    parameter int TIMEOUT_CYC = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic single,
    input  logic pwr_ready,
    input  logic conv_busy,
    input  logic conv_done,
    input  logic ivl_expired,
    input  logic group_done,
    output logic start_now,
    output logic sample_vld,
    output logic publish,
    output logic finish_single,
    output logic grp_clear,
    output logic conv_start,
    output logic timeout
);
    localparam int TO_W = $clog2(TIMEOUT_CYC + 1);
    localparam logic [TO_W-1:0] TO_LAST = TO_W'(TIMEOUT_CYC - 1);

    lcs_state_e      state_q, state_d;
    logic [TO_W-1:0] to_cnt_q;
    logic            start_ok;
    logic            to_fire;

    // a start is possible only when enabled, powered and idle converter
    always_comb start_ok = en && pwr_ready && !conv_busy;

    // next-state and strobe decode
    always_comb begin
        state_d       = state_q;
        start_now     = 1'b0;
        sample_vld    = 1'b0;
        publish       = 1'b0;
        finish_single = 1'b0;
        grp_clear     = 1'b0;
        to_fire       = 1'b0;
        case (state_q)
            ST_IDLE: begin
                grp_clear = !en;
                if (start_ok) begin
                    start_now = 1'b1;
                    state_d   = ST_CONV;
                end
            end
            ST_CONV: begin
                if (conv_done) begin
                    if (!en) begin
                        grp_clear = 1'b1;
                        state_d   = ST_IDLE;
                    end else begin
                        sample_vld = 1'b1;
                        publish    = group_done;
                        if (group_done && single) begin
                            finish_single = 1'b1;
                            state_d       = ST_IDLE;
                        end else begin
                            state_d = ST_GAP;
                        end
                    end
                end else if (to_cnt_q == TO_LAST) begin
                    to_fire   = 1'b1;
                    grp_clear = 1'b1;
                    state_d   = ST_IDLE;
                end
            end
            ST_GAP: begin
                if (!en) begin
                    grp_clear = 1'b1;
                    state_d   = ST_IDLE;
                end else if (ivl_expired && start_ok) begin
                    start_now = 1'b1;
                    state_d   = ST_CONV;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and registered pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            conv_start <= 1'b0;
            timeout    <= 1'b0;
        end else begin
            state_q    <= state_d;
            conv_start <= start_now;
            timeout    <= to_fire;
        end
    end

    // no-answer counter, cleared on start, counting while converting
    always_ff @(posedge clk) begin
        if (!rst_n || start_now)    to_cnt_q <= '0;
        else if (state_q == ST_CONV) to_cnt_q <= to_cnt_q + TO_W'(1);
    end
endmodule

// File: rtl/lcs_chan_sched.sv
// Module: top of one logical conversion channel. It ties together the
// run-state bits, the interval timer, the sequencer and the averaging
// accumulator, and registers the request select and the published result.
// Assumes the converter answers each start with one conv_done pulse.
module lcs_chan_sched
    import lcs_pkg::*;
#(
    parameter int SEL_W       = 4,
    parameter int TMR_W       = 24,
    parameter int RES_W       = 12,
    parameter int TIMEOUT_CYC = 1024
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_stb,
    input  logic                  wr_enable,
    input  logic                  wr_single,
    input  logic [SEL_W-1:0]      cfg_sel,
    input  logic [TMR_W-1:0]      cfg_interval,
    input  logic                  cfg_avg_on,
    input  logic [AVG_CODE_W-1:0] cfg_avg_code,
    input  logic                  pwr_ready,
    input  logic                  conv_busy,
    input  logic                  conv_done,
    input  logic [RES_W-1:0]      conv_data,
    output logic                  conv_start,
    output logic [SEL_W-1:0]      conv_sel,
    output logic [RES_W-1:0]      result,
    output logic                  result_valid,
    output logic                  timeout,
    output logic                  stat_enable,
    output logic                  stat_single
);
    logic             start_now;
    logic             sample_vld;
    logic             publish;
    logic             finish_single;
    logic             grp_clear;
    logic             ivl_expired;
    logic             group_done;
    logic [RES_W-1:0] avg_out;

    lcs_mode_reg u_mode (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_stb       (wr_stb),
        .wr_enable    (wr_enable),
        .wr_single    (wr_single),
        .finish_single(finish_single),
        .en_q         (stat_enable),
        .single_q     (stat_single)
    );

    lcs_ivl_timer #(.TMR_W(TMR_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (start_now),
        .load_val(cfg_interval),
        .expired (ivl_expired)
    );

    lcs_conv_seq #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (stat_enable),
        .single       (stat_single),
        .pwr_ready    (pwr_ready),
        .conv_busy    (conv_busy),
        .conv_done    (conv_done),
        .ivl_expired  (ivl_expired),
        .group_done   (group_done),
        .start_now    (start_now),
        .sample_vld   (sample_vld),
        .publish      (publish),
        .finish_single(finish_single),
        .grp_clear    (grp_clear),
        .conv_start   (conv_start),
        .timeout      (timeout)
    );

    lcs_avg_accum #(.RES_W(RES_W)) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (grp_clear),
        .sample_vld(sample_vld),
        .sample    (conv_data),
        .avg_on    (cfg_avg_on),
        .avg_code  (cfg_avg_code),
        .group_done(group_done),
        .avg_out   (avg_out)
    );

    // select sent with each request, sampled at the start
    always_ff @(posedge clk) begin
        if (!rst_n)         conv_sel <= '0;
        else if (start_now) conv_sel <= cfg_sel;
    end

    // published result and its pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result       <= '0;
            result_valid <= 1'b0;
        end else begin
            result_valid <= publish;
            if (publish) result <= avg_out;
        end
    end
endmodule

// File: rtl/lcs_chan_sched_chk.sv
// Module: protocol checker for lcs_chan_sched, attached by bind.
// It observes ports only.
module lcs_chan_sched_chk #(
    parameter int RES_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_stb,
    input logic             wr_enable,
    input logic             pwr_ready,
    input logic             conv_busy,
    input logic             conv_start,
    input logic [RES_W-1:0] result,
    input logic             result_valid,
    input logic             timeout,
    input logic             stat_enable,
    input logic             stat_single
);
    p_start_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> ($past(pwr_ready) && !$past(conv_busy) && $past(stat_enable)));

    p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    p_single_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid && $past(stat_single && stat_enable && !wr_stb))
        |-> (!stat_enable && !stat_single));

    p_locked_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_enable && wr_stb && wr_enable)
        |=> ((stat_single == $past(stat_single)) || !stat_enable));

    p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);

    p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid |-> $stable(result));

    p_timeout_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> !result_valid);
endmodule

bind lcs_chan_sched lcs_chan_sched_chk #(.RES_W(RES_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_stb      (wr_stb),
    .wr_enable   (wr_enable),
    .pwr_ready   (pwr_ready),
    .conv_busy   (conv_busy),
    .conv_start  (conv_start),
    .result      (result),
    .result_valid(result_valid),
    .timeout     (timeout),
    .stat_enable (stat_enable),
    .stat_single (stat_single)
);

// File: tb/lcs_chan_sched_tb.sv
module lcs_chan_sched_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SEL_W = 4;
    localparam int TMR_W = 24;
    localparam int RES_W = 12;
    localparam int TO_CYC = 40;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_stb = 1'b0, wr_enable = 1'b0, wr_single = 1'b0;
    logic [SEL_W-1:0] cfg_sel = '0;
    logic [TMR_W-1:0] cfg_interval = '0;
    logic             cfg_avg_on = 1'b0;
    logic [1:0]       cfg_avg_code = '0;
    logic             pwr_ready = 1'b1;
    logic             conv_busy = 1'b0, conv_done = 1'b0;
    logic [RES_W-1:0] conv_data = '0;
    logic             conv_start;
    logic [SEL_W-1:0] conv_sel;
    logic [RES_W-1:0] result;
    logic             result_valid, timeout, stat_enable, stat_single;

    int n_chk = 0, n_fail = 0;
    int cyc = 0, prev_start = 0, n_starts = 0, n_results = 0, n_to = 0;
    bit have_prev = 0, chk_period = 0, hang = 0, all_max = 0, done_flag = 0;
    int lat = 2, exp_period = 0;
    int exp_sum = 0, exp_n = 0, last_data = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcs_chan_sched #(.SEL_W(SEL_W), .TMR_W(TMR_W), .RES_W(RES_W), .TIMEOUT_CYC(TO_CYC)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_enable(wr_enable), .wr_single(wr_single),
        .cfg_sel(cfg_sel), .cfg_interval(cfg_interval), .cfg_avg_on(cfg_avg_on),
        .cfg_avg_code(cfg_avg_code), .pwr_ready(pwr_ready), .conv_busy(conv_busy),
        .conv_done(conv_done), .conv_data(conv_data), .conv_start(conv_start),
        .conv_sel(conv_sel), .result(result), .result_valid(result_valid),
        .timeout(timeout), .stat_enable(stat_enable), .stat_single(stat_single));

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cyc);
        end
    endtask

    function automatic int exp_avg(input int sum, input bit on, input int code);
        return on ? (sum >> (code + 2)) : sum;
    endfunction

    function automatic int exp_count(input bit on, input int code);
        return on ? (4 << code) : 1;
    endfunction

    function automatic int spacing(input int ivl, input int l);
        return ((ivl > l + 1) ? ivl : l + 1) + 1;
    endfunction

    // converter model: start/busy/done/data handshake
    initial begin
        forever begin
            @(negedge clk);
            if (conv_start && !hang) begin
                conv_busy = 1'b1;
                repeat (lat) @(negedge clk);
                conv_data = all_max ? 12'hFFF : RES_W'($urandom % 4096);
                last_data = int'(conv_data);
                exp_sum += int'(conv_data);
                exp_n++;
                conv_done = 1'b1;
                @(negedge clk);
                conv_done = 1'b0;
                conv_busy = 1'b0;
            end
        end
    end

    // output monitor
    always @(negedge clk) begin
        cyc++;
        if (rst_n && conv_start) begin
            if (chk_period && have_prev)
                chk(cyc - prev_start == exp_period, "R3 start spacing", cyc - prev_start, exp_period);
            chk(conv_sel == cfg_sel, "R2 conv_sel", int'(conv_sel), int'(cfg_sel));
            prev_start = cyc;
            have_prev = 1;
            n_starts++;
        end
        if (rst_n && result_valid) begin
            n_results++;
            chk(exp_n == exp_count(cfg_avg_on, int'(cfg_avg_code)),
                cfg_avg_on ? "R6 group size" : "R7 group size",
                exp_n, exp_count(cfg_avg_on, int'(cfg_avg_code)));
            chk(int'(result) == exp_avg(exp_sum, cfg_avg_on, int'(cfg_avg_code)),
                cfg_avg_on ? "R6 average" : "R7 raw result",
                int'(result), exp_avg(exp_sum, cfg_avg_on, int'(cfg_avg_code)));
            exp_sum = 0;
            exp_n = 0;
        end
        if (rst_n && timeout) begin
            n_to++;
            chk(cyc - prev_start == TO_CYC, "R9 timeout cycle", cyc - prev_start, TO_CYC);
            chk(!result_valid, "R9 no result", int'(result_valid), 0);
            exp_sum = 0;
            exp_n = 0;
        end
    end

    task automatic wr(input bit e, input bit s);
        @(negedge clk);
        wr_stb = 1'b1; wr_enable = e; wr_single = s;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic wait_results(input int n, input int maxc, input string tag);
        int base = n_results;
        for (int i = 0; i < maxc && n_results < base + n; i++) @(negedge clk);
        chk(n_results >= base + n, tag, n_results - base, n);
    endtask

    task automatic stop_and_flush();
        wr(1'b0, 1'b0);
        chk_period = 0;
        repeat (30) @(negedge clk);
        exp_sum = 0;
        exp_n = 0;
        have_prev = 0;
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        finish_run();
    end

    initial begin
        int s0;
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(conv_start == 0 && result_valid == 0 && timeout == 0, "R1 pulses", 1, 0);
        chk(result == 0, "R1 result", int'(result), 0);
        chk(stat_enable == 0 && stat_single == 0, "R1 run state", int'(stat_enable), 0);

        // R7 + R3 directed: interval dominates
        cfg_interval = 10; lat = 3; cfg_avg_on = 0; cfg_sel = 4'd9;
        exp_period = spacing(10, 3); have_prev = 0; chk_period = 1;
        wr(1'b1, 1'b0);
        wait_results(6, 400, "R7 continuous results");
        stop_and_flush();

        // R3 corner: interval 0 gives back-to-back
        cfg_interval = 0; lat = 2; exp_period = spacing(0, 2); chk_period = 1;
        wr(1'b1, 1'b0);
        wait_results(5, 200, "R3 back-to-back");
        stop_and_flush();

        // R3/R2 random intervals, latencies and selects
        for (int k = 0; k < 6; k++) begin
            cfg_interval = TMR_W'($urandom % 16);
            lat = 1 + int'($urandom % 7);
            cfg_sel = SEL_W'($urandom);
            exp_period = spacing(int'(cfg_interval), lat);
            chk_period = 1;
            wr(1'b1, 1'b0);
            wait_results(4, 600, "R3 random spacing");
            stop_and_flush();
        end

        // R6 all averaging codes, random data
        for (int c = 0; c < 4; c++) begin
            cfg_avg_on = 1; cfg_avg_code = 2'(c); cfg_interval = 1; lat = 1;
            wr(1'b1, 1'b0);
            wait_results(2, 800, "R6 averaged results");
            stop_and_flush();
        end

        // R6 boundary: 32 samples of full scale
        all_max = 1; cfg_avg_code = 2'd3;
        wr(1'b1, 1'b0);
        wait_results(1, 400, "R6 full scale");
        chk(result == 12'hFFF, "R6 full-scale average", int'(result), 4095);
        stop_and_flush();
        all_max = 0;

        // R4 one-shot group
        cfg_avg_on = 1; cfg_avg_code = 2'd0; cfg_interval = 2; lat = 2;
        s0 = n_starts;
        wr(1'b1, 1'b1);
        wait_results(1, 300, "R4 one-shot result");
        chk(stat_enable == 0, "R4 enable cleared", int'(stat_enable), 0);
        chk(stat_single == 0, "R4 single cleared", int'(stat_single), 0);
        repeat (60) @(negedge clk);
        chk(n_starts - s0 == 4, "R4 start count", n_starts - s0, 4);
        stop_and_flush();

        // R5 mode writes while running are ignored
        cfg_avg_on = 0; cfg_interval = 3;
        wr(1'b1, 1'b0);
        wait_results(2, 200, "R5 running");
        wr(1'b1, 1'b1);
        @(negedge clk);
        chk(stat_single == 0, "R5 single ignored", int'(stat_single), 0);
        chk(stat_enable == 1, "R5 still enabled", int'(stat_enable), 1);
        wait_results(2, 200, "R5 continues");
        wr(1'b0, 1'b1);
        chk(stat_enable == 0 && stat_single == 1, "R5 stop write accepted", int'(stat_single), 1);
        stop_and_flush();

        // R2 power gating
        pwr_ready = 0;
        s0 = n_starts;
        wr(1'b1, 1'b0);
        repeat (30) @(negedge clk);
        chk(n_starts == s0, "R2 no start unpowered", n_starts - s0, 0);
        pwr_ready = 1;
        repeat (3) @(negedge clk);
        chk(n_starts == s0 + 1, "R2 start once powered", n_starts - s0, 1);
        stop_and_flush();

        // R9 timeout discards a partial group
        cfg_avg_on = 1; cfg_avg_code = 2'd0; cfg_interval = 0; lat = 2;
        wr(1'b1, 1'b0);
        for (int i = 0; i < 200 && exp_n < 2; i++) @(negedge clk);
        hang = 1;
        s0 = n_to;
        for (int i = 0; i < 200 && n_to == s0; i++) @(negedge clk);
        chk(n_to == s0 + 1, "R9 timeout seen", n_to - s0, 1);
        hang = 0;
        wait_results(1, 300, "R9 recovery");
        stop_and_flush();

        // R10 disable discards a partial group
        cfg_avg_on = 1; cfg_avg_code = 2'd3; cfg_interval = 0; lat = 1;
        wr(1'b1, 1'b0);
        for (int i = 0; i < 200 && exp_n < 5; i++) @(negedge clk);
        stop_and_flush();
        cfg_avg_on = 0;
        wr(1'b1, 1'b0);
        wait_results(1, 100, "R10 fresh group");
        chk(int'(result) == last_data, "R10 fresh result", int'(result), last_data);
        stop_and_flush();

        finish_run();
    end
endmodule